// File: doc/BRIEF.md
# Serial EEPROM Block Fetch Master

This block is a two-wire bus master that pulls a run of configuration bytes out of a single serial EEPROM. It always owns the bus. It generates every clock pulse and places every START, repeated START and STOP itself. Both bus lines are open drain. The block only ever pulls a line low through a pull enable, and otherwise leaves it to the board's pull-up. The data line is read back through an input.

A request is one pulse on `start`, together with a byte count and the EEPROM word address to begin at. The block then runs the complete random-address block read:

1. START.
2. Device select for write.
3. Word address.
4. Repeated START.
5. Device select for read.
6. The requested number of data bytes.
7. STOP.

Each received byte leaves the block with a one-cycle valid strobe. A one-cycle `done` pulse closes the transfer. An `err` level reports whether the EEPROM failed to acknowledge one of the three bytes the master sends.

The bus rate is set by two parameters: the system clock frequency and the bus bit rate, with standard mode (100 kbit/s) as the ceiling. Each bit is split into four equal quarters of `SYS_CLK_HZ/(4*BUS_HZ)` system clocks.

Top module: `eeprom_seqrd_master`

## Requirements
- R1: Out of reset and while idle, neither line is pulled (`scl_pull`=0, `sda_pull`=0), and `rd_valid`, `done` and `err` are 0.
- R2: A `start` pulse is ignored when `byte_cnt` is 0 and while a transfer is in progress. An ignored pulse produces no bus activity and no `done`.
- R3: An accepted request produces exactly this bus sequence: START, byte 0xA0 (device address 7'b1010000 followed by a write bit of 0), the word address, repeated START, byte 0xA1 (the same address followed by a read bit of 1), `byte_cnt` data bytes, then STOP. All bytes are sent MSB first, and each is followed by one acknowledge clock.
- R4: Within a transfer, successive rising edges of SCL are exactly 4*Q system clocks apart, where Q = SYS_CLK_HZ/(4*BUS_HZ). A good transfer of N bytes contains exactly 30+9*N SCL pulses.
- R5: SDA changes while SCL is high only to form a START (falling SDA) or a STOP (rising SDA). A good transfer therefore shows exactly two STARTs and one STOP.
- R6: The master acknowledges (pulls SDA low during the acknowledge clock) every data byte except the last. It leaves the last one unacknowledged (SDA released) before the STOP.
- R7: Every data byte is delivered on `rd_data`, MSB first as received, with a `rd_valid` pulse exactly one cycle wide, in bus order.
- R8: If SDA is high during the acknowledge clock after 0xA0, after the word address or after 0xA1, the block issues STOP, ends with `err`=1, and delivers no data byte.
- R9: `done` is a one-cycle pulse issued after the STOP. `err` is valid with `done` and holds its value until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, one cycle |
| byte_cnt | input | CNT_W | Number of bytes to fetch, sampled with `start` |
| word_addr | input | 8 | First EEPROM word address, sampled with `start` |
| sda_in | input | 1 | Data line as seen on the bus |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | `rd_data` holds a new byte this cycle |
| done | output | 1 | Transfer finished, one cycle |
| err | output | 1 | Last transfer ended on a missing acknowledge |

## Verification
The bench builds the block with SYS_CLK_HZ=8 and BUS_HZ=1, which gives a quarter-bit of two system clocks, and with CNT_W=4 and two synchroniser stages. The short quarter keeps every transfer to a few hundred cycles. That makes it affordable to sweep byte counts from 1 up to the 4-bit maximum of 15, across word addresses at 0x00, mid-range and 0xFE, where the EEPROM pointer wraps. A behavioural EEPROM on the pulled-up lines injects a missing acknowledge at each of the three master-sent bytes in turn. The two-clock quarter also leaves the synchronised acknowledge sample at its tightest margin.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

   localparam logic [6:0] EE_DEV_ADDR = 7'b1010000;

   typedef enum logic [1:0] {
      WV_IDLE,
      WV_START,
      WV_STOP,
      WV_BIT
   } wave_kind_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_START,
      SQ_DEVW,
      SQ_WORD,
      SQ_RSTART,
      SQ_DEVR,
      SQ_DATA,
      SQ_STOP
   } seq_step_t;

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
   parameter int unsigned QTR = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;
   localparam logic [CW-1:0] LAST = CW'(QTR - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!run || cnt == LAST) cnt <= '0;
      else                          cnt <= cnt + CW'(1);
   end

   assign tick = run && (cnt == LAST);

   generate
      if (QTR > 1) begin : g_gap_chk
         // R4: quarters are never shorter than two system clocks
         a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else begin
               r[0] <= din;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign dout = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_slot_wave.sv
module i2c_slot_wave
   import eeprom_rd_pkg::*;
(
   input  wave_kind_t kind,
   input  logic [1:0] ph,
   input  logic       bit_val,
   output logic       scl_low,
   output logic       sda_low
);
   always_comb begin
      unique case (kind)
         WV_START: begin
            scl_low = (ph == 2'd0) || (ph == 2'd3);
            sda_low = ph[1];
         end
         WV_STOP: begin
            scl_low = (ph == 2'd0);
            sda_low = !ph[1];
         end
         WV_BIT: begin
            scl_low = (ph == 2'd0) || (ph == 2'd3);
            sda_low = !bit_val;
         end
         default: begin
            scl_low = 1'b0;
            sda_low = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/eeprom_seqrd_master.sv
module eeprom_seqrd_master
   import eeprom_rd_pkg::*;
#(
   parameter int unsigned SYS_CLK_HZ  = 50_000_000,
   parameter int unsigned BUS_HZ      = 100_000,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] byte_cnt,
   input  logic [7:0]       word_addr,
   input  logic             sda_in,
   output logic             scl_pull,
   output logic             sda_pull,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic             done,
   output logic             err
);
   localparam int unsigned QTR = SYS_CLK_HZ / (4 * BUS_HZ);
   localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

   generate
      if (QTR < 2) begin : g_bad_div
         $error("quarter-bit must span at least two system clocks");
      end
      if (BUS_HZ > 100_000) begin : g_bad_rate
         $error("bus rate above standard mode");
      end
      if (SYNC_STAGES > 3) begin : g_bad_sync
         $error("too many synchroniser stages for the sample point");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("byte count needs at least one bit");
      end
   endgenerate

   seq_step_t        step;
   logic [1:0]       ph;
   logic [3:0]       bitn;
   logic [7:0]       tx_sh;
   logic [7:0]       rx_sh;
   logic [7:0]       word_q;
   logic [CNT_W-1:0] left;
   logic             bad_ack;
   logic             tick;
   logic             sda_s;
   logic             sending;
   wave_kind_t       kind;
   logic             bit_val;
   logic             scl_low;
   logic             sda_low;

   i2c_quarter_tick #(.QTR(QTR)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (step != SQ_IDLE),
      .tick  (tick)
   );

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sda_in),
      .dout  (sda_s)
   );

   assign sending = (step == SQ_DEVW) || (step == SQ_WORD) || (step == SQ_DEVR);

   always_comb begin
      unique case (step)
         SQ_IDLE:             kind = WV_IDLE;
         SQ_START, SQ_RSTART: kind = WV_START;
         SQ_STOP:             kind = WV_STOP;
         default:             kind = WV_BIT;
      endcase
      if (sending)                bit_val = (bitn == 4'd8) ? 1'b1 : tx_sh[7];
      else if (step == SQ_DATA)   bit_val = (bitn == 4'd8) ? (left == ONE_LEFT) : 1'b1;
      else                        bit_val = 1'b1;
   end

   i2c_slot_wave u_wave (
      .kind    (kind),
      .ph      (ph),
      .bit_val (bit_val),
      .scl_low (scl_low),
      .sda_low (sda_low)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
      end else begin
         scl_pull <= scl_low;
         sda_pull <= sda_low;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step     <= SQ_IDLE;
         ph       <= 2'd0;
         bitn     <= 4'd0;
         tx_sh    <= 8'd0;
         rx_sh    <= 8'd0;
         word_q   <= 8'd0;
         left     <= '0;
         bad_ack  <= 1'b0;
         rd_data  <= 8'd0;
         rd_valid <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         done     <= 1'b0;
         if (step == SQ_IDLE) begin
            if (start && (byte_cnt != '0)) begin
               step    <= SQ_START;
               ph      <= 2'd0;
               bitn    <= 4'd0;
               left    <= byte_cnt;
               word_q  <= word_addr;
               bad_ack <= 1'b0;
               err     <= 1'b0;
            end
         end else if (tick) begin
            ph <= ph + 2'd1;
            if (ph == 2'd1) begin
               if (step == SQ_DATA && bitn != 4'd8) rx_sh <= {rx_sh[6:0], sda_s};
               if (sending && bitn == 4'd8)         bad_ack <= sda_s;
            end
            if (ph == 2'd3) begin
               unique case (step)
                  SQ_START: begin
                     step  <= SQ_DEVW;
                     tx_sh <= {EE_DEV_ADDR, 1'b0};
                     bitn  <= 4'd0;
                  end
                  SQ_RSTART: begin
                     step  <= SQ_DEVR;
                     tx_sh <= {EE_DEV_ADDR, 1'b1};
                     bitn  <= 4'd0;
                  end
                  SQ_DEVW, SQ_WORD, SQ_DEVR: begin
                     if (bitn != 4'd8) begin
                        bitn  <= bitn + 4'd1;
                        tx_sh <= {tx_sh[6:0], 1'b0};
                     end else begin
                        bitn <= 4'd0;
                        if (bad_ack) begin
                           step <= SQ_STOP;
                           err  <= 1'b1;
                        end else if (step == SQ_DEVW) begin
                           step  <= SQ_WORD;
                           tx_sh <= word_q;
                        end else if (step == SQ_WORD) begin
                           step <= SQ_RSTART;
                        end else begin
                           step <= SQ_DATA;
                        end
                     end
                  end
                  SQ_DATA: begin
                     if (bitn != 4'd8) begin
                        bitn <= bitn + 4'd1;
                        if (bitn == 4'd7) begin
                           rd_data  <= rx_sh;
                           rd_valid <= 1'b1;
                        end
                     end else begin
                        bitn <= 4'd0;
                        left <= left - ONE_LEFT;
                        if (left == ONE_LEFT) step <= SQ_STOP;
                     end
                  end
                  SQ_STOP: begin
                     step <= SQ_IDLE;
                     done <= 1'b1;
                  end
                  default: step <= SQ_IDLE;
               endcase
            end
         end
      end
   end

   // R1: a block that stays idle leaves both lines released
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (step == SQ_IDLE && $past(step) == SQ_IDLE) |-> (!scl_pull && !sda_pull));

   // R2: a zero-length request never leaves idle
   a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (step == SQ_IDLE && start && byte_cnt == '0) |=> (step == SQ_IDLE));

   // R5: data moves under a high clock only inside START/STOP slots
   a_r5_sda_high_scl: assert property (@(posedge clk) disable iff (!rst_n)
      ((sda_pull != $past(sda_pull)) && !scl_pull && !$past(scl_pull))
      |-> ($past(step) == SQ_START || $past(step) == SQ_RSTART || $past(step) == SQ_STOP));

   // R7: byte strobe is a single cycle
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R8: an aborted transfer never delivers data
   a_r8_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !rd_valid);

   // R9: completion strobe is a single cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/eeprom_seqrd_master_test.sv
module eeprom_seqrd_master_test;
   localparam int QTR_T = 2;
   localparam int CW    = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic          start;
   logic [CW-1:0] byte_cnt;
   logic [7:0]    word_addr;
   logic          scl_pull, sda_pull, rd_valid, done, err;
   logic [7:0]    rd_data;
   logic          s_pull = 1'b0;

   wire scl_line = !scl_pull;
   wire sda_line = !(sda_pull || s_pull);

   eeprom_seqrd_master #(
      .SYS_CLK_HZ (8),
      .BUS_HZ     (1),
      .CNT_W      (CW),
      .SYNC_STAGES(2)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .byte_cnt  (byte_cnt),
      .word_addr (word_addr),
      .sda_in    (sda_line),
      .scl_pull  (scl_pull),
      .sda_pull  (sda_pull),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .done      (done),
      .err       (err)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mv(input logic [7:0] a);
      return a * 8'd37 + 8'd11;
   endfunction

   // bus monitor and behavioural EEPROM
   int n_start = 0, n_stop = 0, n_rise = 0, bad_gap = 0, n_done = 0;
   int n_mack = 0, n_mnack = 0, n_rxb = 0, n_got = 0;
   int cyc = 0, last_rise = 0;
   bit have_prev = 0;
   logic [7:0] rec [512];
   logic [7:0] got [512];
   int inj = 0;

   logic scl_p = 1'b1, sda_p = 1'b1;
   bit s_act = 0, s_rx = 1, first = 0, pend_tx = 0, mack = 0;
   int bc = 0, tx_idx = 0;
   logic [7:0] sh = 8'd0, ptr = 8'd0, tmp;

   always @(negedge clk) begin
      logic sc, sd;
      bit ok;
      sc = scl_line;
      sd = sda_line;
      cyc++;
      if (rst_n) begin
         if (rd_valid) begin got[n_got % 512] = rd_data; n_got++; end
         if (done) begin n_done++; have_prev = 0; end
         if (!scl_p && sc) begin
            n_rise++;
            if (have_prev && (cyc - last_rise) != 4 * QTR_T) bad_gap++;
            have_prev = 1;
            last_rise = cyc;
         end
         if (scl_p && sc && sda_p && !sd) begin
            n_start++; s_act = 1; s_rx = 1; bc = 0; first = 1; s_pull = 0;
         end else if (scl_p && sc && !sda_p && sd) begin
            n_stop++; s_act = 0; s_pull = 0; tx_idx = 0;
         end else if (s_act && !scl_p && sc) begin
            if (s_rx) begin
               if (bc < 8) sh = {sh[6:0], sd};
            end else if (bc == 8) begin
               mack = !sd;
               if (!sd) n_mack++; else n_mnack++;
            end
            bc++;
         end else if (s_act && scl_p && !sc) begin
            if (s_rx) begin
               if (bc == 8) begin
                  rec[n_rxb % 512] = sh; n_rxb++;
                  ok = (!first || sh[7:1] == 7'h50) && !(inj != 0 && tx_idx == inj - 1);
                  pend_tx = ok && first && sh[0];
                  if (!first) ptr = sh;
                  first = 0;
                  tx_idx++;
                  if (ok) s_pull = 1;
                  else begin s_act = 0; s_pull = 0; end
               end else if (bc == 9) begin
                  s_pull = 0; bc = 0;
                  if (pend_tx) begin s_rx = 0; tmp = mv(ptr); s_pull = !tmp[7]; end
               end
            end else begin
               if (bc >= 1 && bc <= 7) begin tmp = mv(ptr); s_pull = !tmp[7-bc]; end
               else if (bc == 8) s_pull = 0;
               else if (bc == 9) begin
                  if (mack) begin ptr = ptr + 8'd1; bc = 0; tmp = mv(ptr); s_pull = !tmp[7]; end
                  else begin s_act = 0; s_pull = 0; end
               end
            end
         end
      end
      scl_p = sc;
      sda_p = sd;
   end

   task automatic run(input int n, input logic [7:0] wa, input int inj_code, input bit poke);
      int b_start, b_stop, b_rise, b_gap, b_mack, b_mnack, b_rxb, b_got;
      bit err_at_done;
      logic [7:0] e;
      b_start = n_start; b_stop = n_stop; b_rise = n_rise; b_gap = bad_gap;
      b_mack = n_mack; b_mnack = n_mnack; b_rxb = n_rxb; b_got = n_got;
      inj = inj_code;
      @(negedge clk);
      byte_cnt = CW'(n); word_addr = wa; start = 1;
      @(negedge clk);
      start = 0;
      if (poke) begin
         repeat (40) @(negedge clk);
         byte_cnt = 1; word_addr = wa + 8'd1; start = 1;
         @(negedge clk);
         start = 0;
      end
      while (!done) @(negedge clk);
      err_at_done = err;
      @(negedge clk);
      check(!done, "R9", "done width", int'(done), 0);
      check(err == err_at_done, "R9", "err held", int'(err), int'(err_at_done));
      check(n_stop - b_stop == 1, "R3", "stop count", n_stop - b_stop, 1);
      if (inj_code == 0) begin
         check(!err_at_done, "R9", "err on good read", int'(err_at_done), 0);
         check(n_start - b_start == 2, poke ? "R2" : "R5", "start count", n_start - b_start, 2);
         check(n_rxb - b_rxb == 3, "R3", "bytes to eeprom", n_rxb - b_rxb, 3);
         check(rec[b_rxb % 512] == 8'hA0, "R3", "write select", int'(rec[b_rxb % 512]), 'hA0);
         check(rec[(b_rxb + 1) % 512] == wa, "R3", "word address", int'(rec[(b_rxb + 1) % 512]), int'(wa));
         check(rec[(b_rxb + 2) % 512] == 8'hA1, "R3", "read select", int'(rec[(b_rxb + 2) % 512]), 'hA1);
         check(n_mack - b_mack == n - 1, "R6", "master acks", n_mack - b_mack, n - 1);
         check(n_mnack - b_mnack == 1, "R6", "final nack", n_mnack - b_mnack, 1);
         check(n_rise - b_rise == 30 + 9 * n, "R4", "scl pulses", n_rise - b_rise, 30 + 9 * n);
         check(bad_gap == b_gap, "R4", "scl period faults", bad_gap - b_gap, 0);
         check(n_got - b_got == n, "R7", "byte strobes", n_got - b_got, n);
         for (int i = 0; i < n; i++) begin
            e = mv(wa + 8'(i));
            check(got[(b_got + i) % 512] == e, "R7", "data byte", int'(got[(b_got + i) % 512]), int'(e));
         end
      end else begin
         check(err_at_done, "R8", "err after nack", int'(err_at_done), 1);
         check(n_got == b_got, "R8", "data after nack", n_got - b_got, 0);
         check(n_rxb - b_rxb == inj_code, "R8", "bytes before abort", n_rxb - b_rxb, inj_code);
         check(n_start - b_start == (inj_code == 3 ? 2 : 1), "R8", "starts before abort",
               n_start - b_start, inj_code == 3 ? 2 : 1);
      end
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int ns[4];
      logic [7:0] was[3];
      int b_rise, b_done;
      ns = '{1, 2, 3, 7};
      was = '{8'h00, 8'h5A, 8'hFE};
      rst_n = 0; start = 0; byte_cnt = 0; word_addr = 0;
      repeat (4) @(negedge clk);
      check(!scl_pull && !sda_pull, "R1", "lines in reset", int'({scl_pull, sda_pull}), 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      check(!scl_pull && !sda_pull, "R1", "lines idle", int'({scl_pull, sda_pull}), 0);
      check(!done && !err && !rd_valid, "R1", "flags idle", int'({done, err, rd_valid}), 0);

      foreach (ns[i]) foreach (was[j]) run(ns[i], was[j], 0, 0);
      run(2, 8'h10, 1, 0);
      run(2, 8'h20, 2, 0);
      run(2, 8'h30, 3, 0);
      run(1, 8'h44, 0, 0);
      run(3, 8'h60, 0, 1);
      run(15, 8'hF8, 0, 0);

      b_rise = n_rise; b_done = n_done;
      @(negedge clk);
      byte_cnt = 0; word_addr = 8'h12; start = 1;
      @(negedge clk);
      start = 0;
      repeat (60) @(negedge clk);
      check(n_rise == b_rise, "R2", "bus idle on zero count", n_rise - b_rise, 0);
      check(n_done == b_done, "R2", "no done on zero count", n_done - b_done, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule